// File: doc/BRIEF.md
# Bus Data-Strobe Handshake Controller

The block sits between a system bus and the data transceiver of a peripheral. The bus starts a transfer by raising either a read strobe or a write strobe. The controller then drives a local strobe toward the device and waits for the device's local acknowledge. It enables the transceiver and finally returns the data acknowledge to the bus. Every handshake is four-phase, so each signal rises once and falls once per transfer.

The controller is a clocked state machine. Its handshake inputs pass through a synchronizer of `SYNC_STAGES` flops. The state is the set of registered outputs plus two extra bits. A phase bit separates states whose external codes coincide, and a kind bit records whether the transfer is a read or a write.

The device side returns to zero independently of the bus. The controller can finish one bus cycle and accept the next strobe while the local acknowledge is still high. It does not issue a new local strobe until that acknowledge has been seen low.

A sticky error flag reports protocol violations by the environment. The flag is set under three conditions:
- both strobes are high while the controller is idle;
- a strobe is withdrawn before it has been acknowledged;
- the device acknowledges while no local strobe is pending.

Top module: `hsc_ctrl`

## Requirements
- R1: Reset drives the outputs bus_ack_o, dev_stb_o, xcvr_en_o and err_o low. After reset, a strobe is not acted on (all outputs stay low) while dev_ack_i is high. A dev_ack_i that is already high at reset is not an error.
- R2: Read cycle. The output triple is written {bus_ack_o, dev_stb_o, xcvr_en_o}. It goes from 000 to 010 after rd_stb_i rises, to 011 after dev_ack_i rises, then to 111 one cycle later. It goes to 110 after rd_stb_i falls, then to 000 one cycle later. No other value appears in between.
- R3: Write cycle, using the same triple. It goes from 000 to 001 after wr_stb_i rises, then to 011 one cycle later. It goes to 010 after dev_ack_i rises, then to 110 one cycle later. It goes to 000 after wr_stb_i falls.
- R4: dev_stb_o falls only in the same cycle as bus_ack_o falls. bus_ack_o rises only while dev_stb_o is high and was high the cycle before.
- R5: A read cycle raises dev_stb_o only if the synchronized dev_ack_i was low in the cycle before.
- R6: A strobe that arrives while dev_ack_i is still high from the previous cycle is held pending, with all outputs low. The cycle starts once dev_ack_i is low.
- R7: If both strobes are sampled high while all outputs are low, err_o is set and no cycle starts: the outputs stay 000.
- R8: If a strobe falls while bus_ack_o is low, err_o is set.
- R9: If dev_ack_i rises while dev_stb_o is low, err_o is set.
- R10: Once set, err_o stays high until reset, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_stb_i | input | 1 | Bus read strobe |
| wr_stb_i | input | 1 | Bus write strobe |
| dev_ack_i | input | 1 | Local acknowledge from the device |
| bus_ack_o | output | 1 | Data acknowledge to the bus |
| dev_stb_o | output | 1 | Local strobe to the device |
| xcvr_en_o | output | 1 | Transceiver enable |
| err_o | output | 1 | Sticky protocol error |

## Verification
A wrong state bit shows up at the ports on the next output step. The controller may skip a phase, for example by raising bus_ack_o without the transceiver enable. It may re-enter a forward phase after release, or it may stall.

Each step is watched cycle by cycle. Any intermediate output triple other than the old or new value counts as a failure, and so does a step that does not arrive within a bounded number of cycles.

A new strobe is held pending while the acknowledge is high, and the outputs are checked on every cycle of that wait. An early local strobe is therefore seen within one cycle of being issued.

Error conditions are checked a few cycles after the violating input, which covers the synchronizer delay. They are checked again after the inputs settle, to confirm the flag is sticky.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic {CYC_RD = 1'b0, CYC_WR = 1'b1} cyc_e;

  typedef struct packed {
    logic ack;  // bus data acknowledge
    logic stb;  // local strobe
    logic en;   // transceiver enable
  } hsc_out_t;
endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES+1];

  assign chain[0] = d_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s+1] <= RST_VAL;
      else         chain[s+1] <= chain[s];
    end
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/hsc_fsm.sv
module hsc_fsm
  import hsc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     ack_i,
  output hsc_out_t out_o
);
  hsc_out_t q, nq;
  logic     fwd_q, fwd_d;   // phase bit: forward half of a cycle
  cyc_e     kind_q, kind_d;

  always_comb begin
    nq     = q;
    fwd_d  = fwd_q;
    kind_d = kind_q;
    if (!fwd_q && !q.ack) begin
      // idle: start only on a single strobe with the device released
      if (!ack_i && rd_i && !wr_i) begin
        nq.stb = 1'b1;
        fwd_d  = 1'b1;
        kind_d = CYC_RD;
      end else if (!ack_i && wr_i && !rd_i) begin
        nq.en  = 1'b1;
        fwd_d  = 1'b1;
        kind_d = CYC_WR;
      end
    end else if (fwd_q && kind_q == CYC_RD) begin
      if (!q.en && !q.ack) begin
        if (ack_i) nq.en = 1'b1;
      end else if (q.en && !q.ack) begin
        nq.ack = 1'b1;
      end else if (q.en && q.ack && !rd_i) begin
        nq.en = 1'b0;
        fwd_d = 1'b0;
      end
    end else if (fwd_q) begin
      if (q.en && !q.stb) begin
        nq.stb = 1'b1;
      end else if (q.en && q.stb) begin
        if (ack_i) nq.en = 1'b0;
      end else if (!q.en && q.stb) begin
        nq.ack = 1'b1;
        fwd_d  = 1'b0;
      end
    end else begin
      // release: local strobe drops together with the bus acknowledge
      if (kind_q == CYC_RD || !wr_i) begin
        nq.ack = 1'b0;
        nq.stb = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q      <= '0;
      fwd_q  <= 1'b0;
      kind_q <= CYC_RD;
    end else begin
      q      <= nq;
      fwd_q  <= fwd_d;
      kind_q <= kind_d;
    end
  end

  assign out_o = q;
endmodule

// File: rtl/hsc_err.sv
module hsc_err
  import hsc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     ack_i,
  input  hsc_out_t out_i,
  output logic     err_o
);
  logic rd_p, wr_p, ack_p, err_q, viol;
  logic idle;

  assign idle = (out_i == '0);

  always_comb begin
    viol = 1'b0;
    if (idle && rd_i && wr_i)                          viol = 1'b1;
    if (((rd_p && !rd_i) || (wr_p && !wr_i)) && !out_i.ack) viol = 1'b1;
    if (ack_i && !ack_p && !out_i.stb)                 viol = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_p  <= 1'b0;
      wr_p  <= 1'b0;
      ack_p <= 1'b1;  // an acknowledge already high at reset is no rise
      err_q <= 1'b0;
    end else begin
      rd_p  <= rd_i;
      wr_p  <= wr_i;
      ack_p <= ack_i;
      err_q <= err_q | viol;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/hsc_ctrl.sv
module hsc_ctrl
  import hsc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_stb_i,
  input  logic wr_stb_i,
  input  logic dev_ack_i,
  output logic bus_ack_o,
  output logic dev_stb_o,
  output logic xcvr_en_o,
  output logic err_o
);
  localparam int unsigned NIN = 3;
  localparam logic [NIN-1:0] IN_RST = 3'b100;

  logic [NIN-1:0] in_s;
  logic           rd_s, wr_s, ack_s;
  hsc_out_t       outs;

  hsc_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dev_ack_i, wr_stb_i, rd_stb_i}),
    .q_o   (in_s)
  );

  assign rd_s  = in_s[0];
  assign wr_s  = in_s[1];
  assign ack_s = in_s[2];

  hsc_fsm u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rd_i  (rd_s),
    .wr_i  (wr_s),
    .ack_i (ack_s),
    .out_o (outs)
  );

  hsc_err u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rd_i  (rd_s),
    .wr_i  (wr_s),
    .ack_i (ack_s),
    .out_i (outs),
    .err_o (err_o)
  );

  assign bus_ack_o = outs.ack;
  assign dev_stb_o = outs.stb;
  assign xcvr_en_o = outs.en;
endmodule

// File: rtl/hsc_chk.sv
module hsc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_ack_o,
  input logic dev_stb_o,
  input logic xcvr_en_o,
  input logic err_o,
  input logic rd_s,
  input logic wr_s,
  input logic ack_s
);
  logic idle;
  assign idle = !bus_ack_o && !dev_stb_o && !xcvr_en_o;

  a_r2_ack_under_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_ack_o) |-> dev_stb_o && $past(dev_stb_o));

  a_r3_en_then_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(xcvr_en_o) && !dev_stb_o) |=> (dev_stb_o && xcvr_en_o));

  a_r4_stb_falls_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_stb_o) |-> $fell(bus_ack_o));

  a_r5_stb_needs_ack_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dev_stb_o) && !$past(xcvr_en_o)) |-> !$past(ack_s));

  a_r7_dual_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && rd_s && wr_s) |=> (err_o && !bus_ack_o && !dev_stb_o && !xcvr_en_o));

  a_r9_stray_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ack_s) && !dev_stb_o) |=> err_o);

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind hsc_ctrl hsc_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bus_ack_o(bus_ack_o),
  .dev_stb_o(dev_stb_o),
  .xcvr_en_o(xcvr_en_o),
  .err_o    (err_o),
  .rd_s     (rd_s),
  .wr_s     (wr_s),
  .ack_s    (ack_s)
);

// File: tb/sim_hsc_ctrl.sv
module sim_hsc_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd = 1'b0, wr = 1'b0, dack = 1'b0;
  logic bus_ack, dev_stb, xcvr_en, err;
  int   checks = 0;
  int   fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  hsc_ctrl u0 (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .rd_stb_i (rd),
    .wr_stb_i (wr),
    .dev_ack_i(dack),
    .bus_ack_o(bus_ack),
    .dev_stb_o(dev_stb),
    .xcvr_en_o(xcvr_en),
    .err_o    (err)
  );

  function automatic logic [2:0] outs();
    return {bus_ack, dev_stb, xcvr_en};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // wait for the outputs to move from pre to post with nothing else in between
  task automatic step(input logic [2:0] pre, input logic [2:0] post, input string req);
    int  n = 0;
    bit  done = 0;
    logic [2:0] v;
    checks++;
    while (!done) begin
      @(negedge clk);
      n++;
      v = outs();
      if (v == post) done = 1;
      else if (v != pre || n > 40) begin
        fails++;
        $display("FAIL %s: outputs %b expected %b (from %b)", req, v, post, pre);
        done = 1;
      end
    end
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    idle_wait(2);
    check(outs() == 3'b000, "R1 reset outputs", outs(), 0);
    check(err == 1'b0, "R1 reset err", err, 0);
    rst_ni = 1'b1;
    idle_wait(2);
  endtask

  // one transfer; if dack is still high the strobe is held pending for hold cycles
  task automatic run_cycle(input bit is_wr, input int hold);
    @(negedge clk);
    if (is_wr) wr = 1'b1; else rd = 1'b1;
    if (dack) begin
      bit ok = 1;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        if (outs() != 3'b000) ok = 0;
      end
      check(ok, "R6 pending strobe held", outs(), 0);
      dack = 1'b0;
    end
    if (!is_wr) begin
      step(3'b000, 3'b010, "R2 stb up");
      idle_wait($urandom_range(0, 4));
      dack = 1'b1;
      step(3'b010, 3'b011, "R2 en up");
      step(3'b011, 3'b111, "R2 ack up");
      idle_wait($urandom_range(0, 4));
      rd = 1'b0;
      step(3'b111, 3'b110, "R2 en down");
      step(3'b110, 3'b000, "R2 release");
    end else begin
      step(3'b000, 3'b001, "R3 en up");
      step(3'b001, 3'b011, "R3 stb up");
      idle_wait($urandom_range(0, 4));
      dack = 1'b1;
      step(3'b011, 3'b010, "R3 en down");
      step(3'b010, 3'b110, "R3 ack up");
      idle_wait($urandom_range(0, 4));
      wr = 1'b0;
      step(3'b110, 3'b000, "R3 release");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: acknowledge high through reset, strobe must wait
    dack = 1'b1;
    idle_wait(3);
    check(outs() == 3'b000, "R1 outputs in reset", outs(), 0);
    rst_ni = 1'b1;
    idle_wait(2);
    run_cycle(1'b0, 10);
    check(err == 1'b0, "R1 no error from initial ack", err, 0);
    idle_wait(2);
    dack = 1'b0;
    idle_wait(6);

    // directed write then overlapped read
    run_cycle(1'b1, 0);
    run_cycle(1'b0, 5);
    idle_wait(1);
    dack = 1'b0;
    idle_wait(6);
    check(err == 1'b0, "R2 R3 clean cycles", err, 0);

    // random mix with overlap of device return-to-zero
    for (int t = 0; t < 60; t++) begin
      run_cycle($urandom_range(0, 1) == 1, $urandom_range(1, 6));
      if ($urandom_range(0, 1) == 0) begin
        idle_wait($urandom_range(0, 5));
        dack = 1'b0;
        idle_wait(6);
      end
    end
    idle_wait(2);
    dack = 1'b0;
    idle_wait(6);
    check(err == 1'b0, "R6 random cycles no error", err, 0);

    // R7: both strobes together
    rd = 1'b1; wr = 1'b1;
    idle_wait(8);
    check(err == 1'b1, "R7 dual strobe err", err, 1);
    check(outs() == 3'b000, "R7 no cycle", outs(), 0);
    rd = 1'b0; wr = 1'b0;
    idle_wait(20);
    check(err == 1'b1, "R10 sticky", err, 1);
    do_reset();

    // R8: read strobe withdrawn early
    rd = 1'b1;
    step(3'b000, 3'b010, "R8 setup");
    rd = 1'b0;
    idle_wait(8);
    check(err == 1'b1, "R8 early withdraw", err, 1);
    do_reset();

    // R8: write strobe withdrawn early
    wr = 1'b1;
    step(3'b000, 3'b001, "R8 setup wr");
    wr = 1'b0;
    idle_wait(8);
    check(err == 1'b1, "R8 early withdraw wr", err, 1);
    do_reset();

    // R9: stray acknowledge
    dack = 1'b1;
    idle_wait(8);
    check(err == 1'b1, "R9 stray ack", err, 1);
    dack = 1'b0;
    idle_wait(10);
    check(err == 1'b1, "R10 sticky after ack drop", err, 1);
    do_reset();
    run_cycle(1'b1, 0);
    idle_wait(1);
    dack = 1'b0;
    idle_wait(6);
    check(err == 1'b0, "R1 clean after reset", err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule